// File: doc/BRIEF.md
# Presettable Synchronous Up-Counter with Two Count Enables

The block is a small synchronous up-counter, four bits wide by default, that can be cleared, loaded from a parallel preset word, or advanced by one on each rising clock edge. Two elaboration-time parameters pick its flavour. `DECADE` chooses a modulus of ten or a full binary modulus. `SYNC_CLR` chooses whether the active-low clear acts at the next rising edge or forces the count to zero at once. Together they give four variants built from one source.

Two enables gate counting, and both must be high for the count to advance. Only the chain enable `en_t` also qualifies the terminal-count output `carry_o`. In a cascade, the low stage's `carry_o` drives the next stage's `en_t`. The local enable `en_p` can then stop one stage without disturbing the carry that stage sends up the chain.

Each cycle an arbiter picks one of four actions: ACT_ZERO (clear), ACT_JAM (load the preset word), ACT_INC (advance by one) and ACT_HOLD (keep the value). The priority order is clear, then load, then increment, then hold. The chosen action selects the next value of the count register. The asynchronous variant has one further path that bypasses the clock: while `clr_n` is low, the count register is held at zero whatever the action.

Top module: `pcnt_counter`

## Requirements
- R1: With SYNC_CLR=0, a low level on `clr_n` forces `count_o` to 0 without waiting for a clock edge, and the count stays 0 while `clr_n` remains low.
- R2: With SYNC_CLR=1, a low `clr_n` sampled at a rising edge makes `count_o` 0 after that edge, and `count_o` does not change before that edge.
- R3: A low `clr_n` takes priority over a low `load_n` and over both enables.
- R4: When `clr_n` is high and `load_n` is low, `count_o` takes the value of `preset_d` at the rising edge, whatever the enables are and whatever the current count is.
- R5: When `clr_n` and `load_n` are both high, `count_o` rises by one at a rising edge only if `en_p` and `en_t` are both 1. Otherwise it keeps its value.
- R6: On an increment, the count goes from the terminal value to 0. The terminal value is 9 with DECADE=1 and 2^WIDTH-1 (15 at WIDTH=4) with DECADE=0. With DECADE=1, a loaded value above 9 also goes to 0 on the next increment.
- R7: `carry_o` is 1 exactly when `en_t` is 1 and `count_o` equals the terminal value. It follows these two signals without a clock edge.
- R8: `en_p` has no effect on `carry_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear, synchronous or asynchronous according to SYNC_CLR |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_p | input | 1 | Local count enable; gates counting only |
| en_t | input | 1 | Chain count enable; gates counting and `carry_o` |
| preset_d | input | WIDTH | Parallel preset word |
| count_o | output | WIDTH | Current count |
| carry_o | output | 1 | Terminal-count carry for cascading |

## Verification
The bench builds two copies side by side and drives them with the same stimulus. The first copy is a decade counter with asynchronous clear. The second is a 4-bit binary counter with synchronous clear. With one stimulus stream, the bench covers both wrap points, a decade load above nine, and a clear that lands in the middle of a cycle; the two copies then react at different times. Both axes of the parameter space are covered, so every requirement is checked in at least one variant.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_ZERO = 2'd1,
        ACT_JAM  = 2'd2,
        ACT_INC  = 2'd3
    } pcnt_act_t;
endpackage

// File: rtl/pcnt_arbiter.sv
module pcnt_arbiter
    import pcnt_pkg::*;
(
    input  logic      clr_n,
    input  logic      load_n,
    input  logic      en_p,
    input  logic      en_t,
    output pcnt_act_t act
);
    // priority: clear, then load, then count, else hold
    always_comb begin
        if (!clr_n)             act = ACT_ZERO;
        else if (!load_n)       act = ACT_JAM;
        else if (en_p && en_t)  act = ACT_INC;
        else                    act = ACT_HOLD;
    end
endmodule

// File: rtl/pcnt_next.sv
module pcnt_next
    import pcnt_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int LAST  = 15
) (
    input  pcnt_act_t        act,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] preset_d,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST);

    always_comb begin
        unique case (act)
            ACT_ZERO: nxt = '0;
            ACT_JAM:  nxt = preset_d;
            ACT_INC:  nxt = (cur >= LAST_V) ? '0 : cur + WIDTH'(1);
            ACT_HOLD: nxt = cur;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/pcnt_carry.sv
module pcnt_carry #(
    parameter int WIDTH = 4,
    parameter int LAST  = 15
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             en_t,
    output logic             carry
);
    localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST);

    always_comb carry = en_t && (cur == LAST_V);
endmodule

// File: rtl/pcnt_counter.sv
module pcnt_counter
    import pcnt_pkg::*;
#(
    parameter int WIDTH    = 4,
    parameter bit DECADE   = 0,
    parameter bit SYNC_CLR = 1
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             en_p,
    input  logic             en_t,
    input  logic [WIDTH-1:0] preset_d,
    output logic [WIDTH-1:0] count_o,
    output logic             carry_o
);
    localparam int LAST = DECADE ? 9 : (2 ** WIDTH) - 1;
    localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST);

    pcnt_act_t        act;
    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] count_d;

    pcnt_arbiter u_arb (
        .clr_n (clr_n),
        .load_n(load_n),
        .en_p  (en_p),
        .en_t  (en_t),
        .act   (act)
    );

    pcnt_next #(.WIDTH(WIDTH), .LAST(LAST)) u_next (
        .act     (act),
        .cur     (count_q),
        .preset_d(preset_d),
        .nxt     (count_d)
    );

    pcnt_carry #(.WIDTH(WIDTH), .LAST(LAST)) u_carry (
        .cur  (count_q),
        .en_t (en_t),
        .carry(carry_o)
    );

    // state register: clear style picked at elaboration
    generate
        if (SYNC_CLR) begin : g_sync_clr
            always_ff @(posedge clk) begin
                count_q <= count_d;
            end
        end else begin : g_async_clr
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) count_q <= '0;
                else        count_q <= count_d;
            end
        end
    endgenerate

    always_comb count_o = count_q;

    // ---------------- assertions ----------------
    logic armed_q = 1'b0;
    always_ff @(posedge clk) begin
        if (!clr_n) armed_q <= 1'b1;
    end

    generate
        if (SYNC_CLR) begin : g_chk_sync
            p_sync_clear_r2: assert property (@(posedge clk) disable iff (!armed_q)
                !clr_n |=> (count_o == '0));
        end else begin : g_chk_async
            p_async_clear_r1: assert property (@(posedge clk) disable iff (!armed_q)
                !clr_n |-> (count_o == '0));
        end
    endgenerate

    p_load_r4: assert property (@(posedge clk) disable iff (!armed_q || !clr_n)
        !load_n |=> (count_o == $past(preset_d)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!armed_q || !clr_n)
        (load_n && !(en_p && en_t)) |=> $stable(count_o));

    p_wrap_r6: assert property (@(posedge clk) disable iff (!armed_q || !clr_n)
        (load_n && en_p && en_t && count_o >= LAST_V) |=> (count_o == '0));

    p_carry_gate_r8: assert property (@(posedge clk) disable iff (!armed_q)
        carry_o |-> (en_t && count_o == LAST_V));
endmodule

// File: tb/test_pcnt_counter.sv
module test_pcnt_counter;
    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       load_n = 1'b1;
    logic       en_p = 1'b0;
    logic       en_t = 1'b0;
    logic [3:0] pre = 4'd0;
    logic [3:0] cnt_a, cnt_b;
    logic       cy_a, cy_b;

    always #5 clk = ~clk;

    // decade, asynchronous clear
    pcnt_counter #(.WIDTH(4), .DECADE(1), .SYNC_CLR(0)) i_pcnt_counter (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
        .preset_d(pre), .count_o(cnt_a), .carry_o(cy_a));

    // binary, synchronous clear
    pcnt_counter #(.WIDTH(4), .DECADE(0), .SYNC_CLR(1)) i_pcnt_counter_bin (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
        .preset_d(pre), .count_o(cnt_b), .carry_o(cy_b));

    int total = 0;
    int bad   = 0;
    int ma = 0, mb = 0;
    bit ka = 0, kb = 0;
    bit done = 0;

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int adv(int q, int last, bit c, bit l, bit p, bit t, int d);
        if (!c) return 0;
        if (!l) return d;
        if (p && t) return (q >= last) ? 0 : q + 1;
        return q;
    endfunction

    // drive at negedge, compare, then advance the model past the rising edge
    task automatic step(bit c, bit l, bit p, bit t, int d, string tag);
        @(negedge clk);
        clr_n = c; load_n = l; en_p = p; en_t = t; pre = 4'(d);
        #1;
        if (!c) begin ma = 0; ka = 1; end   // async variant clears at once (R1)
        if (ka) begin
            chk(tag, "decade/async count", int'(cnt_a), ma);
            chk(tag, "decade/async carry", int'(cy_a), int'(t && ma == 9));
        end
        if (kb) begin
            chk(tag, "binary/sync count", int'(cnt_b), mb);
            chk(tag, "binary/sync carry", int'(cy_b), int'(t && mb == 15));
        end
        @(posedge clk);
        #1;
        ma = adv(ma, 9, c, l, p, t, d);
        if (!c) kb = 1;
        if (kb) mb = adv(mb, 15, c, l, p, t, d);
    endtask

    initial begin
        // R3: clear wins over load and enables; reset state
        step(0, 0, 1, 1, 5, "R3");
        step(0, 0, 1, 1, 5, "R1");
        // R5/R6/R7: free counting through the decade wrap
        for (int i = 0; i < 12; i++) step(1, 1, 1, 1, 0, "R6");
        // R5: en_p low holds
        for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 0, "R5");
        // R5: en_t low holds and carry stays low (R7)
        for (int i = 0; i < 2; i++) step(1, 1, 1, 0, 0, "R7");
        // R4 + R8: load 9 with en_p low, carry stays up on decade copy
        step(1, 0, 0, 0, 9, "R4");
        step(1, 1, 0, 1, 0, "R8");
        step(1, 1, 0, 1, 0, "R8");
        step(1, 1, 1, 0, 0, "R7");
        // load 15: binary terminal, decade above range
        step(1, 0, 1, 1, 15, "R4");
        step(1, 1, 0, 1, 0, "R8");
        step(1, 1, 1, 1, 0, "R6");
        step(1, 1, 1, 1, 0, "R6");
        // R4: load in mid count
        for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 0, "R5");
        step(1, 0, 1, 1, 3, "R4");
        step(1, 1, 1, 1, 0, "R4");
        // R1/R2: clear mid count; async drops at once, sync waits for the edge
        step(1, 1, 1, 1, 0, "R5");
        step(0, 1, 1, 1, 0, "R2");
        step(1, 1, 1, 1, 0, "R2");
        step(1, 1, 1, 1, 0, "R5");
        // binary wrap 15 -> 0
        step(1, 0, 0, 0, 14, "R4");
        for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 0, "R6");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule